// File: doc/BRIEF.md
# Multi-Retrigger Segment Recording Controller

This controller sits between a sampling front end and a bulk memory and records only the stretches of a signal that matter. Each external trigger opens a capture window. While the window is open, every sample strobe produces one write strobe to memory and advances a single linear address. After a fixed number of strobes the window closes and the controller waits for the next trigger. Segments are placed back to back with no gaps, so the idle time between events uses no storage.

After a fixed number of segments the memory counts as full and no further writes happen. A forced-end input stops acquisition early, for example when fewer events occurred than the memory can hold. A readout mode hands the address to a host. Entering readout rewinds the address to zero. Each host read pulse then steps the address by one word, so the stored record is returned in the order it was taken.

All pins are plain control and status signals. No data passes through the block, so there is no valid/ready handshake and no back-pressure. The memory data bus is wired outside the block, and the block only sequences the address, enable and write strobe.

Top module: `rsr_seg_recorder`

## Requirements
- R1: After reset, `mem_addr` is 0, `mem_en_n` is 1, `mem_we` is 0 and `mem_full` is 0.
- R2: The trigger passes through a two-flop synchronizer, and only its rising edge opens the window. Sample strobes that arrive while the window is closed produce no write.
- R3: While the window is open, each cycle with `smp_stb` high produces exactly one single-cycle `mem_we` pulse one cycle later. `mem_en_n` is 0 whenever the window is open or a write is issued, and 1 when the block is idle outside readout.
- R4: `mem_addr` holds the target address during each `mem_we` pulse and increments by one in the following cycle. Addresses run on across segments without gaps, so segment k begins at k*SEG_LEN.
- R5: A window closes after exactly SEG_LEN accepted strobes, so each trigger yields SEG_LEN writes.
- R6: A trigger edge that arrives while a window is open is ignored and does not lengthen the segment.
- R7: Once SEG_MAX segments are complete, `mem_full` goes high and stays high. Later triggers and strobes produce no writes.
- R8: A high `force_end` stops acquisition at once. No further writes follow, `mem_full` goes high, and later triggers are ignored.
- R9: When `rd_mode` rises, `mem_addr` becomes 0 and acquisition stops. While `rd_mode` is high, `mem_en_n` is 0, each `rd_pulse` cycle raises `mem_addr` by one, and no write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | 1 | Asynchronous event trigger; the rising edge counts |
| smp_stb | input | 1 | One-cycle sample strobe from the converter timing |
| force_end | input | 1 | Ends acquisition early |
| rd_mode | input | 1 | High selects host readout |
| rd_pulse | input | 1 | One-cycle host read step |
| mem_addr | output | ADDR_W | Memory word address |
| mem_en_n | output | 1 | Active-low memory enable |
| mem_we | output | 1 | Active-high one-cycle write strobe |
| mem_full | output | 1 | Acquisition finished (segment limit or forced end) |

## Verification
The bench builds the block with SEG_LEN=4, SEG_MAX=3 and ADDR_W=4. At that size every segment boundary, the full limit, the wrap of the segment counter and a readout sweep over the whole record each take only a few dozen cycles. Each run drives every segment in turn, with strobes before the trigger, a second trigger inside the window and extra strobes after the window closes. The expected write count and address sequence follow from k*SEG_LEN arithmetic. A second run after reset cuts a segment short with the forced end.

// File: rtl/rsr_pkg.sv
package rsr_pkg;
  localparam int unsigned RSR_SEG_LEN_DEF = 8192;
  localparam int unsigned RSR_SEG_MAX_DEF = 64;
  localparam int unsigned RSR_ADDR_W_DEF  = 19;
  localparam int unsigned RSR_SYNC_DEF    = 2;

  typedef enum logic [1:0] {
    ACQ_IDLE = 2'd0,
    ACQ_OPEN = 2'd1,
    ACQ_DONE = 2'd2
  } acq_state_t;
endpackage

// File: rtl/rsr_trig_sync.sv
module rsr_trig_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES:0] chain;

  // Synchronizer stages followed by one history flop for edge detection
  for (genvar g = 0; g <= STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= 1'b0;
        else        chain[g] <= chain[g-1];
      end
    end
  end

  assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/rsr_window.sv
module rsr_window
  import rsr_pkg::*;
#(
  parameter int unsigned SEG_LEN = RSR_SEG_LEN_DEF,
  parameter int unsigned SEG_MAX = RSR_SEG_MAX_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_rise,
  input  logic smp_stb,
  input  logic halt,
  output logic win_open,
  output logic take,
  output logic done
);
  localparam int unsigned CNT_W = (SEG_LEN > 1) ? $clog2(SEG_LEN) : 1;
  localparam int unsigned SEG_W = $clog2(SEG_MAX + 1);
  localparam logic [CNT_W-1:0] LAST_STB = CNT_W'(SEG_LEN - 1);
  localparam logic [SEG_W-1:0] LAST_SEG = SEG_W'(SEG_MAX - 1);

  acq_state_t       state;
  logic [CNT_W-1:0] stb_cnt;
  logic [SEG_W-1:0] seg_cnt;

  assign win_open = (state == ACQ_OPEN);
  assign take     = win_open & smp_stb & ~halt;
  assign done     = (state == ACQ_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ACQ_IDLE;
      stb_cnt <= '0;
      seg_cnt <= '0;
    end else if (halt) begin
      state   <= ACQ_DONE;
      stb_cnt <= '0;
    end else begin
      case (state)
        ACQ_IDLE: if (trig_rise) state <= ACQ_OPEN;
        ACQ_OPEN: if (smp_stb) begin
          if (stb_cnt == LAST_STB) begin
            stb_cnt <= '0;
            seg_cnt <= seg_cnt + 1'b1;
            state   <= (seg_cnt == LAST_SEG) ? ACQ_DONE : ACQ_IDLE;
          end else begin
            stb_cnt <= stb_cnt + 1'b1;
          end
        end
        default: state <= ACQ_DONE;
      endcase
    end
  end
endmodule

// File: rtl/rsr_addr_gen.sv
module rsr_addr_gen #(
  parameter int unsigned ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              rd_mode,
  input  logic              rd_pulse,
  output logic [ADDR_W-1:0] addr,
  output logic              we
);
  logic rd_mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr      <= '0;
      we        <= 1'b0;
      rd_mode_q <= 1'b0;
    end else begin
      rd_mode_q <= rd_mode;
      we        <= take;
      if (rd_mode && !rd_mode_q)  addr <= '0;
      else if (rd_mode)           addr <= addr + ADDR_W'(rd_pulse);
      else if (we)                addr <= addr + 1'b1;
    end
  end
endmodule

// File: rtl/rsr_seg_recorder.sv
module rsr_seg_recorder
  import rsr_pkg::*;
#(
  parameter int unsigned SEG_LEN = RSR_SEG_LEN_DEF,
  parameter int unsigned SEG_MAX = RSR_SEG_MAX_DEF,
  parameter int unsigned ADDR_W  = RSR_ADDR_W_DEF,
  parameter int unsigned SYNC    = RSR_SYNC_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_in,
  input  logic              smp_stb,
  input  logic              force_end,
  input  logic              rd_mode,
  input  logic              rd_pulse,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_en_n,
  output logic              mem_we,
  output logic              mem_full
);
  logic trig_rise, win_open, take, done;

  rsr_trig_sync #(.STAGES(SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(trig_in), .rise(trig_rise)
  );

  rsr_window #(.SEG_LEN(SEG_LEN), .SEG_MAX(SEG_MAX)) u_win (
    .clk(clk), .rst_n(rst_n), .trig_rise(trig_rise), .smp_stb(smp_stb),
    .halt(force_end | rd_mode), .win_open(win_open), .take(take), .done(done)
  );

  rsr_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .take(take), .rd_mode(rd_mode),
    .rd_pulse(rd_pulse), .addr(mem_addr), .we(mem_we)
  );

  assign mem_en_n = ~(win_open | mem_we | rd_mode);
  assign mem_full = done;
endmodule

// File: rtl/rsr_checker.sv
module rsr_checker #(
  parameter int unsigned ADDR_W = 19
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_mode,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_en_n,
  input logic              mem_we,
  input logic              mem_full
);
  // R3: a write is never issued with the memory deselected
  a_r3_we_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !mem_en_n);

  // R4: each write is followed by a one-word address step
  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !rd_mode) |=> (rd_mode || mem_addr == $past(mem_addr) + 1'b1));

  // R7 / R8: once finished, the done flag holds and no write follows
  a_r7_full_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    mem_full |=> mem_full);
  a_r8_no_write_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_full && $past(mem_full)) |-> !mem_we);

  // R9: readout rewinds the address and never writes
  a_r9_read_rewind: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_mode) |=> (mem_addr == '0));
  a_r9_read_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_mode && $past(rd_mode)) |-> !mem_we);
endmodule

bind rsr_seg_recorder rsr_checker #(.ADDR_W(ADDR_W)) u_rsr_chk (
  .clk(clk), .rst_n(rst_n), .rd_mode(rd_mode), .mem_addr(mem_addr),
  .mem_en_n(mem_en_n), .mem_we(mem_we), .mem_full(mem_full)
);

// File: tb/test_rsr_seg_recorder.sv
module test_rsr_seg_recorder;
  localparam int SEG_LEN = 4;
  localparam int SEG_MAX = 3;
  localparam int ADDR_W  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig_in = 1'b0, smp_stb = 1'b0, force_end = 1'b0;
  logic rd_mode = 1'b0, rd_pulse = 1'b0;
  logic [ADDR_W-1:0] mem_addr;
  logic mem_en_n, mem_we, mem_full;

  int n_cmp = 0, n_bad = 0, n_wr = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  rsr_seg_recorder #(.SEG_LEN(SEG_LEN), .SEG_MAX(SEG_MAX), .ADDR_W(ADDR_W), .SYNC(2))
    i_rsr_seg_recorder (.*);

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // R4: every write must land on the next word of the linear record
  always @(negedge clk) if (rst_n && mem_we) begin
    check("R4 write address", int'(mem_addr), n_wr);
    n_wr++;
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic strobes(input int n);
    for (int i = 0; i < n; i++) begin
      smp_stb = 1'b1; cyc(1); smp_stb = 1'b0; cyc(1);
    end
  endtask

  task automatic trigger();
    trig_in = 1'b1; cyc(4); trig_in = 1'b0; cyc(3);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cyc(2); rst_n = 1'b1; cyc(1); n_wr = 0;
  endtask

  initial begin
    cyc(1);
    do_reset();
    @(negedge clk);
    check("R1 addr", int'(mem_addr), 0);
    check("R1 en_n", int'(mem_en_n), 1);
    check("R1 we", int'(mem_we), 0);
    check("R1 full", int'(mem_full), 0);
    cyc(1);
    strobes(3);
    check("R2 no write before trigger", n_wr, 0);

    for (int k = 0; k < SEG_MAX + 1; k++) begin
      trigger();
      @(negedge clk);
      check("R3 en_n in window", int'(mem_en_n), (k < SEG_MAX) ? 0 : 1);
      cyc(1);
      strobes(SEG_LEN / 2);
      trigger(); // R6: ignored while open
      strobes(SEG_LEN / 2 + 3);
      cyc(2);
      check("R5 R6 writes per segment", n_wr, ((k + 1 < SEG_MAX) ? k + 1 : SEG_MAX) * SEG_LEN);
      check("R3 en_n idle", int'(mem_en_n), 1);
      check("R7 full flag", int'(mem_full), (k + 1 >= SEG_MAX) ? 1 : 0);
    end

    rd_mode = 1'b1; cyc(2);
    @(negedge clk);
    check("R9 read start addr", int'(mem_addr), 0);
    check("R9 read en_n", int'(mem_en_n), 0);
    cyc(1);
    for (int i = 1; i <= SEG_LEN * SEG_MAX; i++) begin
      rd_pulse = 1'b1; cyc(1); rd_pulse = 1'b0; cyc(1);
      check("R9 read step", int'(mem_addr), i % (1 << ADDR_W));
    end
    strobes(2);
    check("R9 no write in readout", n_wr, SEG_LEN * SEG_MAX);
    rd_mode = 1'b0; cyc(2);

    do_reset();
    trigger();
    strobes(2);
    force_end = 1'b1; cyc(1); force_end = 1'b0; cyc(2);
    check("R8 full after force", int'(mem_full), 1);
    strobes(3);
    trigger();
    strobes(SEG_LEN);
    check("R8 writes after force", n_wr, 2);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule